// File: doc/BRIEF.md
# Biased Round-Robin Unit Selector

This block picks a single execution unit (a port or pipeline) out of a group of up to `N_UNITS` units. On a cycle where a select request is raised, it looks at which units in the group are ready and answers one cycle later with a registered one-hot grant. It keeps a round mask of units that have not yet been granted in the current round. Each grant removes its unit from that mask. When the mask empties, it reloads, so every unit in the group gets a turn before any unit is granted twice.

Groups of units may overlap, so another selector can consume a unit that this group also contains. Those external uses are reported on a separate input. The block records them in a one-level "taken elsewhere" mask and prefers units that are not in that mask until the round reloads. The group's membership is fixed by a parameter mask. Ready bits outside that mask are ignored.

Top module: `unit_rr_picker`

## Requirements
- R1: After reset the round mask equals the full group mask `UNIT_MASK`, the taken-elsewhere mask is empty, and `grant_valid` is low.
- R2: A select with at least one ready unit inside the group produces `grant_valid` high on the next cycle. `grant` then has exactly one bit set, and that bit is a ready group unit. Bit i of `grant` stands for unit i.
- R3: Among the eligible candidates, the unit with the highest index is granted. With all units ready, one round grants the units in descending index order.
- R4: A granted unit is removed from the round mask. It is not granted again in the same round while some other unit in the round is ready.
- R5: When a grant empties the round mask, the round mask reloads to `UNIT_MASK` and the taken-elsewhere mask clears.
- R6: If no ready unit remains in the round but some group unit is ready, the round reloads at once and the highest ready group unit is granted. The new round mask is `UNIT_MASK` minus that unit.
- R7: A `used_valid` pulse adds `used_mask & UNIT_MASK` to the taken-elsewhere mask. Ready round units outside that mask are granted before those inside it.
- R8: If every ready unit in the round is in the taken-elsewhere mask, the highest ready unit in the round is still granted.
- R9: The taken-elsewhere mask is one level deep. Reporting a unit several times in one round has the same effect as reporting it once. Every reload clears the mask.
- R10: With `sel_valid` low, or with no ready unit inside the group, `grant_valid` stays low and the round mask does not change. Ready bits outside `UNIT_MASK` are never granted.
- R11: When select and used arrive in the same cycle, the grant of that cycle ignores the new used mask. The used mask is applied after the grant's round update, so it survives a reload made by that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Request a grant this cycle |
| ready_mask | input | N_UNITS | Units able to accept work this cycle |
| used_valid | input | 1 | An overlapping group consumed units this cycle |
| used_mask | input | N_UNITS | Units consumed by the overlapping group |
| grant_valid | output | 1 | Registered: a unit was granted for last cycle's request |
| grant | output | N_UNITS | Registered one-hot granted unit |

## Verification
The assertions assume only that the inputs are known after reset. They place no restriction on how `ready_mask` and `used_mask` relate to each other or to the group. The stimulus therefore drives ready bits outside the group, used bits that overlap the current round, and select and used together in the same cycle. It combines directed rounds with a long stretch of random masks, and a behavioural model predicts every cycle's grant.

// File: rtl/unit_rr_pkg.sv
package unit_rr_pkg;

    // Which candidate set produced the pick
    typedef enum logic [1:0] {
        TIER_FRESH  = 2'd0,  // ready, in round, not taken elsewhere
        TIER_ROUND  = 2'd1,  // ready, in round
        TIER_RELOAD = 2'd2,  // round exhausted for ready units; start over
        TIER_NONE   = 2'd3   // nothing ready in the group
    } tier_e;

endpackage

// File: rtl/unit_rr_msb_pick.sv
module unit_rr_msb_pick #(
    parameter int N_UNITS = 8
) (
    input  logic [N_UNITS-1:0] req,
    output logic [N_UNITS-1:0] pick
);

    localparam int TOP = N_UNITS - 1;

    // above[i] is set when any request with index greater than i is present
    logic [N_UNITS-1:0] above;

    assign above[TOP] = 1'b0;
    assign pick[TOP]  = req[TOP];

    generate
        for (genvar i = TOP - 1; i >= 0; i--) begin : g_chain
            assign above[i] = above[i+1] | req[i+1];
            assign pick[i]  = req[i] & ~above[i];
        end
    endgenerate

    always_comb begin
        a_r3_pick_onehot: assert ($onehot0(pick));
        a_r3_pick_subset: assert ((pick & ~req) == '0);
    end

endmodule

// File: rtl/unit_rr_tier_sel.sv
module unit_rr_tier_sel
    import unit_rr_pkg::*;
#(
    parameter int N_UNITS = 8
) (
    input  logic [N_UNITS-1:0] rdy,
    input  logic [N_UNITS-1:0] round,
    input  logic [N_UNITS-1:0] taken,
    output logic [N_UNITS-1:0] cand,
    output tier_e              tier
);

    logic [N_UNITS-1:0] fresh_set;
    logic [N_UNITS-1:0] round_set;

    assign fresh_set = rdy & round & ~taken;
    assign round_set = rdy & round;

    always_comb begin
        if (fresh_set != '0) begin
            cand = fresh_set;
            tier = TIER_FRESH;
        end else if (round_set != '0) begin
            cand = round_set;
            tier = TIER_ROUND;
        end else if (rdy != '0) begin
            cand = rdy;
            tier = TIER_RELOAD;
        end else begin
            cand = '0;
            tier = TIER_NONE;
        end
    end

    always_comb begin
        a_r8_cand_ready: assert ((cand & ~rdy) == '0);
    end

endmodule

// File: rtl/unit_rr_picker.sv
module unit_rr_picker
    import unit_rr_pkg::*;
#(
    parameter int                    N_UNITS   = 8,
    parameter logic [N_UNITS-1:0]    UNIT_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_valid,
    input  logic [N_UNITS-1:0] ready_mask,
    input  logic               used_valid,
    input  logic [N_UNITS-1:0] used_mask,
    output logic               grant_valid,
    output logic [N_UNITS-1:0] grant
);

    localparam logic [N_UNITS-1:0] FULL_ROUND = UNIT_MASK;
    localparam logic [N_UNITS-1:0] NO_UNITS   = '0;

    typedef struct packed {
        logic [N_UNITS-1:0] round;
        logic [N_UNITS-1:0] taken;
        logic               gnt_vld;
        logic [N_UNITS-1:0] gnt;
    } state_t;

    state_t st_q;
    state_t st_d;

    logic [N_UNITS-1:0] rdy_in_group;
    logic [N_UNITS-1:0] cand;
    logic [N_UNITS-1:0] pick;
    tier_e              tier;

    assign rdy_in_group = ready_mask & UNIT_MASK;

    unit_rr_tier_sel #(
        .N_UNITS (N_UNITS)
    ) u_tier (
        .rdy   (rdy_in_group),
        .round (st_q.round),
        .taken (st_q.taken),
        .cand  (cand),
        .tier  (tier)
    );

    unit_rr_msb_pick #(
        .N_UNITS (N_UNITS)
    ) u_pick (
        .req  (cand),
        .pick (pick)
    );

    always_comb begin
        logic [N_UNITS-1:0] round_v;
        logic [N_UNITS-1:0] taken_v;

        round_v    = st_q.round;
        taken_v    = st_q.taken;
        st_d.gnt_vld = 1'b0;
        st_d.gnt     = NO_UNITS;

        if (sel_valid && tier != TIER_NONE) begin
            if (tier == TIER_RELOAD) begin
                round_v = FULL_ROUND;
                taken_v = NO_UNITS;
            end
            round_v      = round_v & ~pick;
            st_d.gnt_vld = 1'b1;
            st_d.gnt     = pick;
            if (round_v == NO_UNITS) begin
                round_v = FULL_ROUND;
                taken_v = NO_UNITS;
            end
        end

        // External uses land after this cycle's grant has updated the round
        if (used_valid) begin
            taken_v = taken_v | (used_mask & UNIT_MASK);
        end

        st_d.round = round_v;
        st_d.taken = taken_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.round   <= FULL_ROUND;
            st_q.taken   <= NO_UNITS;
            st_q.gnt_vld <= 1'b0;
            st_q.gnt     <= NO_UNITS;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.gnt_vld;
    assign grant       = st_q.gnt;

    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $countones(grant) == 1);

    a_r2_grant_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && (ready_mask & UNIT_MASK) != '0)
        |=> grant_valid && (grant & $past(ready_mask) & UNIT_MASK) != '0);

    a_r10_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> !grant_valid);

    a_r10_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && (ready_mask & UNIT_MASK) == '0)
        |=> !grant_valid && $stable(st_q.round));

    a_r10_grant_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~UNIT_MASK) == '0);

    a_r5_round_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.round != '0);

    a_r9_taken_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.taken & ~UNIT_MASK) == '0);

    a_r11_used_keeps_round: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid && used_valid) |=> $stable(st_q.round));

endmodule

// File: tb/unit_rr_picker_tb.sv
module unit_rr_picker_tb;

    localparam int         N    = 8;
    localparam logic [7:0] MASK = 8'hF7;  // unit 3 not in the group

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_valid = 1'b0;
    logic [7:0] ready_mask = '0;
    logic       used_valid = 1'b0;
    logic [7:0] used_mask = '0;
    logic       grant_valid;
    logic [7:0] grant;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Behavioural model state
    bit [7:0] m_round;
    bit [7:0] m_taken;

    always #2.5 clk = ~clk;

    unit_rr_picker #(
        .N_UNITS   (N),
        .UNIT_MASK (MASK)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_valid   (sel_valid),
        .ready_mask  (ready_mask),
        .used_valid  (used_valid),
        .used_mask   (used_mask),
        .grant_valid (grant_valid),
        .grant       (grant)
    );

    function automatic int top_index(input bit [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) return i;
        end
        return -1;
    endfunction

    task automatic check(input string tag, input bit ev, input bit [7:0] eg);
        tests++;
        if (grant_valid !== ev || (ev && grant !== eg)) begin
            fails++;
            $display("FAIL %s: got valid=%0b grant=%h expected valid=%0b grant=%h",
                     tag, grant_valid, grant, ev, eg);
        end
    endtask

    // One cycle: drive, clock, update model, compare
    task automatic step(input string tag, input bit s, input bit [7:0] r,
                        input bit uv, input bit [7:0] um);
        bit       ev;
        bit [7:0] eg;
        bit [7:0] elig;
        int       idx;
        @(negedge clk);
        sel_valid  = s;
        ready_mask = r;
        used_valid = uv;
        used_mask  = um;
        @(posedge clk);
        ev = 1'b0;
        eg = '0;
        if (s && (r & MASK) != 0) begin
            elig = r & MASK & m_round & ~m_taken;
            if (elig == 0) elig = r & MASK & m_round;
            if (elig == 0) begin
                m_round = MASK;
                m_taken = '0;
                elig    = r & MASK;
            end
            idx = top_index(elig);
            eg  = 8'(1) << idx;
            ev  = 1'b1;
            m_round = m_round & ~eg;
            if (m_round == 0) begin
                m_round = MASK;
                m_taken = '0;
            end
        end
        if (uv) m_taken = m_taken | (um & MASK);
        #1;
        check(tag, ev, eg);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_round = MASK;
        m_taken = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        step("R1 idle after reset", 0, 8'hFF, 0, 8'h00);

        // R3 R4 R5: full round in descending order, unit 3 excluded
        step("R3 first pick", 1, 8'hFF, 0, 8'h00);
        step("R4 second pick", 1, 8'hFF, 0, 8'h00);
        step("R3 third pick", 1, 8'hFF, 0, 8'h00);
        step("R4 fourth pick", 1, 8'hFF, 0, 8'h00);
        step("R10 skip non-member", 1, 8'hFF, 0, 8'h00);
        step("R4 sixth pick", 1, 8'hFF, 0, 8'h00);
        step("R5 last in round", 1, 8'hFF, 0, 8'h00);
        step("R5 after reload", 1, 8'hFF, 0, 8'h00);

        // R10: nothing ready, or only a non-member ready
        step("R10 none ready", 1, 8'h00, 0, 8'h00);
        step("R10 only outside group", 1, 8'h08, 0, 8'h00);
        step("R10 round unchanged", 1, 8'hFF, 0, 8'h00);

        // R6: the only ready unit already granted this round
        step("R6 single ready", 1, 8'h80, 0, 8'h00);
        step("R6 forced reload", 1, 8'h80, 0, 8'h00);
        step("R6 new round content", 1, 8'hFF, 0, 8'h00);

        // R7: units taken elsewhere lose priority
        step("R7 report use", 0, 8'h00, 1, 8'h20);
        step("R7 skip taken unit", 1, 8'h30, 0, 8'h00);
        step("R8 only taken left", 1, 8'h20, 0, 8'h00);

        // R9: repeated reports, then reload clears them
        step("R9 report once", 0, 8'h00, 1, 8'h04);
        step("R9 report twice", 0, 8'h00, 1, 8'h04);
        step("R9 taken avoided", 1, 8'h06, 0, 8'h00);
        step("R9 fallback", 1, 8'h04, 0, 8'h00);

        // R11: select and use in the same cycle
        step("R11 grant ignores same-cycle use", 1, 8'hFF, 1, 8'hFF);
        step("R11 use applied next", 1, 8'hFF, 0, 8'h00);

        // Random traffic against the model
        for (int k = 0; k < 600; k++) begin
            step("R2 random",
                 ($urandom % 4) != 0,
                 8'($urandom),
                 ($urandom % 3) == 0,
                 8'($urandom));
        end

        step("R10 final idle", 0, 8'hFF, 0, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule